// File: doc/BRIEF.md
# Hardware Performance Counter Bank

This block holds the 64-bit counters that let software measure a processor: a free-running cycle counter, a counter of retired instructions, and a parameterised set of event counters. Each counter is reached through the control-register port as two 32-bit halves. A machine-level inhibit register can freeze any implemented counter, and every event counter has its own 16-bit selector that picks which of the sixteen event inputs it counts. Read-only user-level aliases of all counter halves are also decoded here. A write to one of these aliases is refused and flagged.

The access port is a plain single-cycle register port and has no back-pressure. When `csr_en` is high, `csr_rdata` and `csr_illegal` are valid combinationally in that same cycle. A write is applied on the rising clock edge that ends the cycle. The retire input and the event inputs are sampled once per cycle as level pulses. Counter slots are numbered 0 to 31: slot 0 is the cycle counter, slot 1 is never implemented, slot 2 is the retired counter, and event counter k sits in slot 3+k.

Top module: `hpc_bank`

## Requirements
- R1: After reset every counter and every selector reads 0, and the inhibit register (address 0x320) reads with bits 0, 2 and 3..NUM_EVT_CNT+2 set and all other bits clear. For NUM_EVT_CNT=3 this value is 0x0000003D.
- R2: While inhibit bit 0 is clear, the cycle counter increments on every clock edge. Its low half is read at 0xB00 and its high half at 0xB80.
- R3: Only inhibit bits 0, 2 and 3..NUM_EVT_CNT+2 are writable. Bit 1 and the bits of unimplemented slots always read 0.
- R4: The retired counter (halves 0xB02/0xB82) increments by one on each edge at which `retire_pulse` is high and inhibit bit 2 is clear.
- R5: Event counter k (halves 0xB03+k/0xB83+k) increments by one on an edge where inhibit bit 3+k is clear and at least one input is high in (`event_pulse` AND its selector). Selector k is at 0x323+k. It stores bits 15:0, and bits 31:16 read 0.
- R6: A write to either half of a counter loads that half. No increment is applied to that counter on that edge, so the written value is read back unchanged in the next cycle.
- R7: When the low half is 0xFFFFFFFF and an increment is applied, the low half becomes 0 and the high half increases by one.
- R8: User addresses 0xC00+i and 0xC80+i read the same value as 0xB00+i and 0xB80+i. A write to them drives `csr_illegal` high in that cycle and changes nothing.
- R9: Slot 1 and slots above NUM_EVT_CNT+2, together with their selectors, read 0. Writes to them are ignored and do not raise `csr_illegal`.
- R10: `csr_rdata` is 0 whenever `csr_en` is low. `csr_illegal` is high only for writes to the user aliases.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| csr_en | input | 1 | Register access in this cycle |
| csr_we | input | 1 | Access is a write |
| csr_addr | input | 12 | Register address |
| csr_wdata | input | 32 | Write data |
| retire_pulse | input | 1 | One instruction retired this cycle |
| event_pulse | input | EVT_W (16) | Event inputs, one bit per event |
| csr_rdata | output | 32 | Read data, combinational |
| csr_illegal | output | 1 | Refused access (write to read-only alias) |

## Verification
The assertions check the following on every cycle:
- a frozen counter with no write holds its value;
- a written low half reads back exactly;
- the carry moves into the high half on wrap;
- a selector loads what was written;
- the port stays quiet while idle;
- the inhibit register comes out of reset with only the implemented bits set.

Only the bench scenarios can show that counts match the number of stimulus pulses:
- retire pulses and selector-masked random events;
- the inhibit mask and the unimplemented slots reading 0;
- user aliases mirroring the machine halves and faulting on writes;
- a write taking precedence over a concurrent increment.

// File: rtl/hpc_pkg.sv
package hpc_pkg;
  localparam int unsigned XLEN    = 32;
  localparam int unsigned CNT_W   = 64;
  localparam int unsigned MAX_EVT = 29;
  localparam int unsigned NSLOT   = 32;

  localparam logic [11:0] INH_ADDR = 12'h320;
  localparam logic [6:0]  BLK_SEL  = 7'h19;
  localparam logic [6:0]  BLK_MLO  = 7'h58;
  localparam logic [6:0]  BLK_MHI  = 7'h5C;
  localparam logic [6:0]  BLK_ULO  = 7'h60;
  localparam logic [6:0]  BLK_UHI  = 7'h64;

  typedef struct packed {
    logic       inh;
    logic       sel;
    logic       mlo;
    logic       mhi;
    logic       ulo;
    logic       uhi;
    logic [4:0] idx;
  } dec_t;

  function automatic logic [NSLOT-1:0] impl_mask(int unsigned n_evt);
    logic [NSLOT-1:0] m;
    m = '0;
    m[0] = 1'b1;
    m[2] = 1'b1;
    for (int unsigned i = 0; i < MAX_EVT; i++) begin
      if (i < n_evt) m[3+i] = 1'b1;
    end
    return m;
  endfunction
endpackage

// File: rtl/hpc_decode.sv
module hpc_decode
  import hpc_pkg::*;
(
  input  logic [11:0] addr,
  output dec_t        dec
);
  logic [6:0] blk;
  assign blk = addr[11:5];

  always_comb begin
    dec     = '0;
    dec.idx = addr[4:0];
    dec.inh = (addr == INH_ADDR);
    dec.sel = (blk == BLK_SEL) && (addr[4:0] >= 5'd3);
    dec.mlo = (blk == BLK_MLO);
    dec.mhi = (blk == BLK_MHI);
    dec.ulo = (blk == BLK_ULO);
    dec.uhi = (blk == BLK_UHI);
  end
endmodule

// File: rtl/hpc_evsel.sv
module hpc_evsel #(
  parameter int unsigned EVT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr,
  input  logic [EVT_W-1:0] wdata,
  input  logic [EVT_W-1:0] events,
  output logic [EVT_W-1:0] sel_q,
  output logic             hit
);
  always_ff @(posedge clk) begin
    if (!rst_n)  sel_q <= '0;
    else if (wr) sel_q <= wdata;
  end

  assign hit = |(sel_q & events);

  // R5: a selector write is stored as given
  a_r5_sel_loads: assert property (@(posedge clk) disable iff (!rst_n)
    wr |=> sel_q == $past(wdata));
endmodule

// File: rtl/hpc_counter.sv
module hpc_counter #(
  parameter int unsigned CNT_W  = 64,
  parameter int unsigned HALF_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              inc,
  input  logic              wr_lo,
  input  logic              wr_hi,
  input  logic [HALF_W-1:0] wdata,
  output logic [CNT_W-1:0]  value
);
  localparam int unsigned HI_W = CNT_W - HALF_W;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      value <= '0;
    end else if (wr_lo || wr_hi) begin
      if (wr_lo) value[HALF_W-1:0]     <= wdata;
      if (wr_hi) value[CNT_W-1:HALF_W] <= HI_W'(wdata);
    end else if (inc) begin
      value <= value + CNT_W'(1);
    end
  end

  // R6: a low-half write wins over a same-cycle increment
  a_r6_write_wins: assert property (@(posedge clk) disable iff (!rst_n)
    wr_lo |=> value[HALF_W-1:0] == $past(wdata));

  // R2: no increment and no write means the counter holds
  a_r2_hold_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (!inc && !wr_lo && !wr_hi) |=> $stable(value));

  // R7: wrap of the low half carries into the high half
  a_r7_carry: assert property (@(posedge clk) disable iff (!rst_n)
    (inc && !wr_lo && !wr_hi && (&value[HALF_W-1:0])) |=>
      (value[HALF_W-1:0] == '0) &&
      (value[CNT_W-1:HALF_W] == HI_W'($past(value[CNT_W-1:HALF_W]) + HI_W'(1))));
endmodule

// File: rtl/hpc_bank.sv
module hpc_bank
  import hpc_pkg::*;
#(
  parameter int unsigned NUM_EVT_CNT = 1,
  parameter int unsigned EVT_W       = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             csr_en,
  input  logic             csr_we,
  input  logic [11:0]      csr_addr,
  input  logic [XLEN-1:0]  csr_wdata,
  input  logic             retire_pulse,
  input  logic [EVT_W-1:0] event_pulse,
  output logic [XLEN-1:0]  csr_rdata,
  output logic             csr_illegal
);
  localparam logic [NSLOT-1:0] MASK = impl_mask(NUM_EVT_CNT);

  dec_t             dec;
  logic             wr_any;
  logic [NSLOT-1:0] inh_q;
  logic [CNT_W-1:0] cnt   [NSLOT];
  logic [EVT_W-1:0] sel_q [MAX_EVT];
  logic [MAX_EVT-1:0] ev_hit;
  logic [4:0]       sidx;

  hpc_decode u_dec (.addr(csr_addr), .dec(dec));

  assign wr_any = csr_en && csr_we;
  assign sidx   = dec.idx - 5'd3;

  // inhibit register: only implemented slots hold a bit
  always_ff @(posedge clk) begin
    if (!rst_n)                inh_q <= MASK;
    else if (wr_any && dec.inh) inh_q <= csr_wdata & MASK;
  end

  // event selectors
  for (genvar k = 0; k < MAX_EVT; k++) begin : g_sel
    if (k < NUM_EVT_CNT) begin : g_on
      hpc_evsel #(.EVT_W(EVT_W)) u_sel (
        .clk   (clk),
        .rst_n (rst_n),
        .wr    (wr_any && dec.sel && (dec.idx == 5'(k + 3))),
        .wdata (csr_wdata[EVT_W-1:0]),
        .events(event_pulse),
        .sel_q (sel_q[k]),
        .hit   (ev_hit[k])
      );
    end else begin : g_off
      assign sel_q[k]  = '0;
      assign ev_hit[k] = 1'b0;
    end
  end

  // counter slots
  for (genvar i = 0; i < NSLOT; i++) begin : g_slot
    if (MASK[i]) begin : g_on
      logic inc;
      if (i == 0) begin : g_cyc
        assign inc = ~inh_q[0];
      end else if (i == 2) begin : g_ret
        assign inc = ~inh_q[2] & retire_pulse;
      end else begin : g_evt
        assign inc = ~inh_q[i] & ev_hit[i-3];
      end
      hpc_counter #(.CNT_W(CNT_W), .HALF_W(XLEN)) u_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .inc   (inc),
        .wr_lo (wr_any && dec.mlo && (dec.idx == 5'(i))),
        .wr_hi (wr_any && dec.mhi && (dec.idx == 5'(i))),
        .wdata (csr_wdata),
        .value (cnt[i])
      );
    end else begin : g_off
      assign cnt[i] = '0;
    end
  end

  // read path
  always_comb begin
    csr_rdata = '0;
    if (csr_en) begin
      if (dec.inh)                csr_rdata = inh_q;
      else if (dec.sel)           csr_rdata = XLEN'(sel_q[sidx]);
      else if (dec.mlo || dec.ulo) csr_rdata = cnt[dec.idx][XLEN-1:0];
      else if (dec.mhi || dec.uhi) csr_rdata = cnt[dec.idx][CNT_W-1:XLEN];
    end
  end

  assign csr_illegal = wr_any && (dec.ulo || dec.uhi);

  // R10: an idle port returns nothing and flags nothing
  a_r10_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !csr_en |-> (csr_rdata == '0) && !csr_illegal);

  // R1: on leaving reset only implemented inhibit bits are set
  a_r1_inhibit_reset: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> inh_q == MASK);
endmodule

// File: tb/tb_hpc_bank.sv
module tb_hpc_bank;
  localparam int unsigned NE = 3;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        csr_en, csr_we, retire_pulse, csr_illegal;
  logic [11:0] csr_addr;
  logic [31:0] csr_wdata, csr_rdata;
  logic [15:0] event_pulse;

  int total = 0;
  int fails = 0;
  logic ill;

  always #5 clk = ~clk;

  hpc_bank #(.NUM_EVT_CNT(NE), .EVT_W(16)) dut (
    .clk(clk), .rst_n(rst_n), .csr_en(csr_en), .csr_we(csr_we),
    .csr_addr(csr_addr), .csr_wdata(csr_wdata), .retire_pulse(retire_pulse),
    .event_pulse(event_pulse), .csr_rdata(csr_rdata), .csr_illegal(csr_illegal)
  );

  function automatic logic [31:0] exp_mask(int unsigned n);
    logic [31:0] m = 32'h5;
    for (int unsigned i = 0; i < n; i++) m[3+i] = 1'b1;
    return m;
  endfunction

  function automatic logic ev_match(logic [15:0] s, logic [15:0] e);
    return |(s & e);
  endfunction

  task automatic chk(string r, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", r, act, exp);
    end
  endtask

  task automatic wr(logic [11:0] a, logic [31:0] d);
    @(negedge clk);
    csr_en = 1'b1; csr_we = 1'b1; csr_addr = a; csr_wdata = d;
    #1 ill = csr_illegal;
    @(negedge clk);
    csr_en = 1'b0; csr_we = 1'b0;
  endtask

  task automatic rd(logic [11:0] a, output logic [31:0] d);
    csr_en = 1'b1; csr_we = 1'b0; csr_addr = a;
    #1 d = csr_rdata;
    csr_en = 1'b0;
  endtask

  initial begin
    #(200000 * 10);
    fails++; total++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    logic [31:0] d, e0, e1, rc;
    logic [15:0] ev;
    void'($urandom(32'd7));
    rst_n = 1'b0; csr_en = 1'b0; csr_we = 1'b0; csr_addr = '0; csr_wdata = '0;
    retire_pulse = 1'b0; event_pulse = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd(12'h320, d); chk("R1 inhibit", d, exp_mask(NE));
    chk("R1 inhibit value", d, 32'h3D);
    rd(12'hB00, d); chk("R1 cycle lo", d, 0);
    rd(12'hB80, d); chk("R1 cycle hi", d, 0);
    rd(12'hB02, d); chk("R1 retire lo", d, 0);
    rd(12'hB03, d); chk("R1 event lo", d, 0);
    rd(12'h323, d); chk("R1 selector", d, 0);

    // R3 writable mask
    wr(12'h320, 32'hFFFF_FFFF); rd(12'h320, d); chk("R3 all ones", d, 32'h3D);
    wr(12'h320, 32'h0000_0002); rd(12'h320, d); chk("R3 bit1 zero", d, 0);
    wr(12'h320, 32'h3D);

    // R2 cycle counting
    wr(12'hB00, 0); wr(12'hB80, 0);
    wr(12'h320, 32'h3C);
    repeat (10) @(negedge clk);
    rd(12'hB00, d); chk("R2 cycle count", d, 10);
    rd(12'hC00, d); chk("R8 user alias lo", d, 10);

    // R6 write wins over increment
    wr(12'hB00, 100);
    rd(12'hB00, d); chk("R6 write wins", d, 100);
    @(negedge clk);
    rd(12'hB00, d); chk("R6 counts after write", d, 101);

    // R7 carry
    wr(12'h320, 32'h3D);
    wr(12'hB00, 32'hFFFF_FFFE); wr(12'hB80, 5);
    wr(12'h320, 32'h3C);
    repeat (3) @(negedge clk);
    rd(12'hB00, d); chk("R7 low wrapped", d, 1);
    rd(12'hB80, d); chk("R7 high carried", d, 6);
    rd(12'hC80, d); chk("R8 user alias hi", d, 6);
    wr(12'h320, 32'h3D);

    // R4 retired counter, random pulses
    wr(12'h320, 32'h39);
    rc = 0;
    for (int i = 0; i < 60; i++) begin
      @(negedge clk);
      retire_pulse = $urandom_range(0, 1);
      rc += retire_pulse;
    end
    @(negedge clk); retire_pulse = 1'b0;
    rd(12'hB02, d); chk("R4 retire count", d, rc);
    rd(12'hB82, d); chk("R4 retire hi", d, 0);
    wr(12'h320, 32'h3D);
    for (int i = 0; i < 5; i++) begin
      @(negedge clk); retire_pulse = 1'b1;
    end
    @(negedge clk); retire_pulse = 1'b0;
    rd(12'hB02, d); chk("R4 inhibited retire", d, rc);

    // R5 event counters
    wr(12'h323, 32'h0001_0001); rd(12'h323, d); chk("R5 selector upper zero", d, 32'h1);
    wr(12'h324, 32'h8003);
    wr(12'h325, 32'hFFFF); rd(12'h325, d); chk("R5 selector full", d, 32'hFFFF);
    wr(12'h320, 32'h25);
    e0 = 0; e1 = 0;
    for (int i = 0; i < 80; i++) begin
      @(negedge clk);
      ev = 16'($urandom) & (($urandom_range(0, 1) == 1) ? 16'hFFFF : 16'h7FF8);
      event_pulse = ev;
      e0 += ev_match(16'h0001, ev);
      e1 += ev_match(16'h8003, ev);
    end
    @(negedge clk); event_pulse = '0;
    rd(12'hB03, d); chk("R5 event0 count", d, e0);
    rd(12'hB04, d); chk("R5 event1 count", d, e1);
    rd(12'hB05, d); chk("R5 inhibited event2", d, 0);
    rd(12'hC03, d); chk("R8 user alias event0", d, e0);
    wr(12'h320, 32'h3D);

    // R8 alias write faults and changes nothing
    wr(12'hB00, 32'h1234_5678); chk("R10 machine write legal", ill, 0);
    wr(12'hC00, 32'hDEAD_BEEF); chk("R8 alias write illegal", ill, 1);
    rd(12'hB00, d); chk("R8 alias write ignored", d, 32'h1234_5678);
    wr(12'hC80, 32'h1); chk("R8 alias hi write illegal", ill, 1);
    rd(12'hB80, d); chk("R8 alias hi write ignored", d, 6);

    // R9 unimplemented slots
    rd(12'hB01, d); chk("R9 slot1 reads zero", d, 0);
    wr(12'hB06, 32'hFFFF); chk("R9 no fault", ill, 0);
    rd(12'hB06, d); chk("R9 slot6 reads zero", d, 0);
    rd(12'hC86, d); chk("R9 slot6 alias zero", d, 0);
    wr(12'h326, 32'hFFFF); rd(12'h326, d); chk("R9 selector reads zero", d, 0);

    // R10 idle port
    @(negedge clk); #1;
    chk("R10 idle rdata", csr_rdata, 0);
    chk("R10 idle illegal", {31'd0, csr_illegal}, 0);

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule